// File: doc/BRIEF.md
# Paged Indirect PHY Register Access Engine

This engine lets one requester read or write a 16-bit internal register address inside a serial PHY. The PHY is reached only through a small memory-mapped window. Every window access takes two steps. First the engine writes a page value that selects the PHY device and the upper address bits. Then it reads or writes the word inside the window. Inside the PHY, the target register is not reached directly. The engine drives a three-register command port for control, address and data. Before it issues a command, it polls the busy bit of the control register, waiting a fixed number of cycles between polls.

A request enters through a valid/ready handshake. `req_ready` is high only while the engine is idle. The request is taken on the cycle where `req_valid` and `req_ready` are both high. A valid that arrives while ready is low is not stored and does nothing. The response is a one-cycle `rsp_done` pulse with `rsp_err` and `rsp_rdata`. The response cannot be held back, so the requester must capture it in that cycle. On the fabric side, each transfer holds a read or write strobe until the slave raises `bus_ack`.

Top module: `phy_reg_engine`

## Requirements
- R1: Every window access is directly preceded by a write to byte offset 0x800. The written value is the device number in bits [11:7] and target address bits [15:9] in bits [6:0], with all upper bits zero.
- R2: The window byte offset of a target address is its bits [8:0] times four. The command port (control 0x80A0, address 0x80A1, data 0x80A2) therefore appears at offsets 0x280, 0x284 and 0x288, all under page value (device<<7)|0x40.
- R3: A read polls control until not busy, writes the address register, writes control with value 1, polls until not busy again, then reads the data register.
- R4: A write polls until not busy, writes the address register, writes the data register, then writes control with value 3 (bit 1 = write, bit 0 = start). It finishes without any further poll.
- R5: Control bit 0 is the busy flag. After a poll returns busy, at least POLL_GAP cycles pass before the strobe of the next poll.
- R6: If POLL_MAX polls in a row return busy in one poll phase, the request ends with `rsp_done` and `rsp_err` both high. No further bus transfer follows for that request.
- R7: `req_ready` is high only when idle. It goes low the cycle after acceptance and stays low until the cycle in which `rsp_done` is high. A `req_valid` given while `req_ready` is low causes no bus activity.
- R8: `rsp_done` lasts exactly one cycle. On a successful read, `rsp_rdata` equals the value returned by the final data-register read.
- R9: `bus_rd` and `bus_wr` are never high together. While a strobe is high and `bus_ack` is low, the strobe, `bus_addr` and `bus_wdata` stay unchanged.
- R10: During and right after reset, `req_ready` is high and `bus_rd`, `bus_wr` and `rsp_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | PHY device number |
| req_addr | input | 16 | PHY internal register address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Busy-poll timeout, valid with rsp_done |
| rsp_rdata | output | DATA_W | Read result, valid with rsp_done |
| bus_addr | output | 12 | Window byte offset |
| bus_wr | output | 1 | Write strobe, held until ack |
| bus_rd | output | 1 | Read strobe, held until ack |
| bus_wdata | output | DATA_W | Write data to window |
| bus_rdata | input | DATA_W | Read data, sampled with ack |
| bus_ack | input | 1 | Transfer completes this cycle |

## Verification
Assertions check on every cycle that the strobes are exclusive and held until ack, that a read strobe rises only right after an acknowledged page write, that `rsp_done` is a single pulse that comes back together with `req_ready`, and that an error never appears without done. The exact order of transfers, the page values and offsets, the spacing between polls, the timeout count and the read data can only be shown by the bench scenarios. These run against a PHY slave model with random ack delays and random busy durations, and compare the whole bus trace of each request with an expected trace.

// File: rtl/phy_eng_pkg.sv
package phy_eng_pkg;
  localparam int DEV_W   = 5;
  localparam int IADDR_W = 16;
  localparam int BUS_AW  = 12;
  localparam int OFS_W   = 9;
  localparam int PAGE_W  = DEV_W + (IADDR_W - OFS_W);
  localparam logic [BUS_AW-1:0] PAGE_OFS = 12'h800;
  localparam logic [IADDR_W-1:0] CMD_CTL = 16'h80A0;
  localparam logic [IADDR_W-1:0] CMD_ADR = 16'h80A1;
  localparam logic [IADDR_W-1:0] CMD_DAT = 16'h80A2;
  typedef enum logic [2:0] {S_IDLE, S_POLL, S_WAIT, S_ADDR, S_DATA, S_GO, S_FETCH} seq_st_t;
  typedef enum logic [1:0] {W_IDLE, W_PAGE, W_ACC} win_st_t;
endpackage

// File: rtl/phy_eng_gap.sv
module phy_eng_gap #(
  parameter int GAP = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(GAP + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= CW'(GAP);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/phy_eng_window.sv
module phy_eng_window import phy_eng_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic               op_write,
  input  logic [DEV_W-1:0]   op_dev,
  input  logic [IADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0]  op_wdata,
  output logic               op_done,
  output logic [DATA_W-1:0]  op_rdata,
  output logic [BUS_AW-1:0]  bus_addr,
  output logic               bus_wr,
  output logic               bus_rd,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_rdata,
  input  logic               bus_ack
);
  localparam int OPAD = BUS_AW - OFS_W - 2;

  win_st_t            st;
  logic               l_write;
  logic [DEV_W-1:0]   l_dev;
  logic [IADDR_W-1:0] l_addr;
  logic [DATA_W-1:0]  l_wdata;
  logic [PAGE_W-1:0]  page_val;
  logic [BUS_AW-1:0]  win_ofs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= W_IDLE;
      l_write <= 1'b0;
      l_dev <= '0;
      l_addr <= '0;
      l_wdata <= '0;
    end else begin
      case (st)
        W_IDLE: if (op_valid) begin
          l_write <= op_write;
          l_dev <= op_dev;
          l_addr <= op_addr;
          l_wdata <= op_wdata;
          st <= W_PAGE;
        end
        W_PAGE: if (bus_ack) st <= W_ACC;
        W_ACC:  if (bus_ack) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  assign page_val  = {l_dev, l_addr[IADDR_W-1:OFS_W]};
  assign win_ofs   = {{OPAD{1'b0}}, l_addr[OFS_W-1:0], 2'b00};
  assign bus_wr    = (st == W_PAGE) || ((st == W_ACC) && l_write);
  assign bus_rd    = (st == W_ACC) && !l_write;
  assign bus_addr  = (st == W_PAGE) ? PAGE_OFS : win_ofs;
  assign bus_wdata = (st == W_PAGE) ? {{(DATA_W-PAGE_W){1'b0}}, page_val} : l_wdata;
  assign op_done   = (st == W_ACC) && bus_ack;
  assign op_rdata  = bus_rdata;

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_wr)
      && $stable(bus_rd) && $stable(bus_wdata)));
  assert_page_before_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |-> $past(bus_wr && bus_ack && (bus_addr == PAGE_OFS)));
endmodule

// File: rtl/phy_eng_seq.sv
module phy_eng_seq import phy_eng_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int POLL_MAX = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [DEV_W-1:0]   req_dev,
  input  logic [IADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_done,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               op_valid,
  output logic               op_write,
  output logic [DEV_W-1:0]   op_dev,
  output logic [IADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0]  op_wdata,
  input  logic               op_done,
  input  logic [DATA_W-1:0]  op_rdata,
  output logic               gap_load,
  input  logic               gap_done
);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam logic [PW-1:0] LAST_POLL = PW'(POLL_MAX - 1);

  seq_st_t            st;
  logic               after_cmd;
  logic [PW-1:0]      polls;
  logic               r_write;
  logic [DEV_W-1:0]   r_dev;
  logic [IADDR_W-1:0] r_addr;
  logic [DATA_W-1:0]  r_wdata;
  logic               busy;

  assign busy      = op_rdata[0];
  assign req_ready = (st == S_IDLE);
  assign op_dev    = r_dev;
  assign op_valid  = (st == S_POLL) || (st == S_ADDR) || (st == S_DATA)
                  || (st == S_GO) || (st == S_FETCH);
  assign op_write  = (st == S_ADDR) || (st == S_DATA) || (st == S_GO);
  assign gap_load  = (st == S_POLL) && op_done && busy && (polls != LAST_POLL);

  always_comb begin
    op_addr  = CMD_CTL;
    op_wdata = '0;
    case (st)
      S_ADDR: begin
        op_addr  = CMD_ADR;
        op_wdata = {{(DATA_W-IADDR_W){1'b0}}, r_addr};
      end
      S_DATA: begin
        op_addr  = CMD_DAT;
        op_wdata = r_wdata;
      end
      S_GO:    op_wdata = {{(DATA_W-2){1'b0}}, r_write, 1'b1};
      S_FETCH: op_addr  = CMD_DAT;
      default: op_addr  = CMD_CTL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      after_cmd <= 1'b0;
      polls <= '0;
      r_write <= 1'b0;
      r_dev <= '0;
      r_addr <= '0;
      r_wdata <= '0;
      rsp_done <= 1'b0;
      rsp_err <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          r_write <= req_write;
          r_dev <= req_dev;
          r_addr <= req_addr;
          r_wdata <= req_wdata;
          after_cmd <= 1'b0;
          polls <= '0;
          st <= S_POLL;
        end
        S_POLL: if (op_done) begin
          if (busy) begin
            if (polls == LAST_POLL) begin
              st <= S_IDLE;
              rsp_done <= 1'b1;
              rsp_err <= 1'b1;
            end else begin
              polls <= polls + 1'b1;
              st <= S_WAIT;
            end
          end else begin
            polls <= '0;
            st <= after_cmd ? S_FETCH : S_ADDR;
          end
        end
        S_WAIT: if (gap_done) st <= S_POLL;
        S_ADDR: if (op_done) st <= r_write ? S_DATA : S_GO;
        S_DATA: if (op_done) st <= S_GO;
        S_GO: if (op_done) begin
          if (r_write) begin
            st <= S_IDLE;
            rsp_done <= 1'b1;
          end else begin
            after_cmd <= 1'b1;
            st <= S_POLL;
          end
        end
        S_FETCH: if (op_done) begin
          st <= S_IDLE;
          rsp_done <= 1'b1;
          rsp_rdata <= op_rdata;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_done_with_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  assert_err_only_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);
endmodule

// File: rtl/phy_reg_engine.sv
module phy_reg_engine import phy_eng_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int POLL_GAP = 625,
  parameter int POLL_MAX = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [DEV_W-1:0]   req_dev,
  input  logic [IADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_done,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [BUS_AW-1:0]  bus_addr,
  output logic               bus_wr,
  output logic               bus_rd,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_rdata,
  input  logic               bus_ack
);
  logic               op_valid, op_write, op_done, gap_load, gap_done;
  logic [DEV_W-1:0]   op_dev;
  logic [IADDR_W-1:0] op_addr;
  logic [DATA_W-1:0]  op_wdata, op_rdata;

  phy_eng_seq #(.DATA_W(DATA_W), .POLL_MAX(POLL_MAX)) u_seq (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_dev, .req_addr,
    .req_wdata, .rsp_done, .rsp_err, .rsp_rdata, .op_valid, .op_write,
    .op_dev, .op_addr, .op_wdata, .op_done, .op_rdata, .gap_load, .gap_done
  );

  phy_eng_gap #(.GAP(POLL_GAP)) u_gap (
    .clk, .rst_n, .load(gap_load), .expired(gap_done)
  );

  phy_eng_window #(.DATA_W(DATA_W)) u_win (
    .clk, .rst_n, .op_valid, .op_write, .op_dev, .op_addr, .op_wdata,
    .op_done, .op_rdata, .bus_addr, .bus_wr, .bus_rd, .bus_wdata,
    .bus_rdata, .bus_ack
  );
endmodule

// File: tb/sim_phy_reg_engine.sv
module sim_phy_reg_engine;
  localparam int PG = 6;
  localparam int PM = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_dev = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_done, rsp_err, bus_wr, bus_rd;
  logic [31:0] rsp_rdata, bus_wdata;
  logic [11:0] bus_addr;
  logic [31:0] bus_rdata = '0;
  logic bus_ack = 1'b0;

  int checks = 0, failures = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phy_reg_engine #(.DATA_W(32), .POLL_GAP(PG), .POLL_MAX(PM)) u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_dev, .req_addr,
    .req_wdata, .rsp_done, .rsp_err, .rsp_rdata, .bus_addr, .bus_wr, .bus_rd,
    .bus_wdata, .bus_rdata, .bus_ack
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] init_val(input int i);
    return 32'h1000_0000 + i * 32'h0001_0203;
  endfunction

  // PHY slave model
  logic [31:0] phy_mem [0:63];
  logic [31:0] ref_mem [0:63];
  logic [11:0] page = '0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_data = '0;
  int busy_left = 0, post_busy = 0, wait_left = 0;
  int last_busy_cyc = 0;
  bit have_busy = 0;

  bit          t_wr [0:127];
  logic [11:0] t_a  [0:127];
  logic [31:0] t_d  [0:127];
  int t_n = 0;
  bit          e_wr [0:127];
  logic [11:0] e_a  [0:127];
  logic [31:0] e_d  [0:127];
  int e_n = 0;

  always @(negedge clk) begin
    logic [15:0] ia;
    logic [31:0] rd;
    if (bus_ack) begin
      bus_ack = 1'b0;
      wait_left = $urandom % 3;
    end else if (bus_wr || bus_rd) begin
      if (wait_left > 0) wait_left--;
      else begin
        ia = {page[6:0], bus_addr[10:2]};
        rd = '0;
        if (bus_wr && bus_addr == 12'h800) page = bus_wdata[11:0];
        else if (bus_wr) begin
          if (ia == 16'h80A1) reg_addr = bus_wdata[15:0];
          else if (ia == 16'h80A2) reg_data = bus_wdata;
          else if (ia == 16'h80A0 && bus_wdata[0]) begin
            if (bus_wdata[1]) phy_mem[reg_addr[5:0]] = reg_data;
            else begin
              reg_data = phy_mem[reg_addr[5:0]];
              busy_left = post_busy;
            end
          end
        end else begin
          if (ia == 16'h80A0) begin
            if (have_busy)  // R5 spacing after a busy poll
              chk(cyc - last_busy_cyc >= PG, "R5 poll spacing", cyc - last_busy_cyc, PG);
            rd = {31'b0, busy_left > 0};
            have_busy = (busy_left > 0);
            if (busy_left > 0) begin
              busy_left--;
              last_busy_cyc = cyc;
            end
          end else if (ia == 16'h80A2) rd = reg_data;
        end
        bus_rdata = rd;
        if (t_n < 128) begin
          t_wr[t_n] = bus_wr;
          t_a[t_n] = bus_addr;
          t_d[t_n] = bus_wr ? bus_wdata : rd;
        end
        t_n++;
        bus_ack = 1'b1;
      end
    end
  end

  task automatic push(input bit wr, input logic [11:0] a, input logic [31:0] d);
    e_wr[e_n] = wr; e_a[e_n] = a; e_d[e_n] = d; e_n++;
  endtask

  task automatic exp_poll(input int nb, input logic [31:0] pv, output bit to);
    for (int i = 0; i < nb && i < PM; i++) begin
      push(1, 12'h800, pv); push(0, 12'h280, 32'd1);
    end
    to = (nb >= PM);
    if (!to) begin
      push(1, 12'h800, pv); push(0, 12'h280, 32'd0);
    end
  endtask

  task automatic do_req(input bit wr, input logic [4:0] dev, input logic [15:0] addr,
                        input logic [31:0] wd, input int pre, input int post, input bit inject);
    logic [31:0] pv;
    bit to;
    int waited, n_after;
    bit ready_bad;
    logic [31:0] exp_rd;
    pv = {20'b0, dev, 7'h40};
    e_n = 0;
    exp_rd = ref_mem[addr[5:0]];
    exp_poll(pre, pv, to);
    if (!to) begin
      push(1, 12'h800, pv); push(1, 12'h284, {16'b0, addr});
      if (wr) begin push(1, 12'h800, pv); push(1, 12'h288, wd); end
      push(1, 12'h800, pv); push(1, 12'h280, wr ? 32'd3 : 32'd1);
      if (!wr) begin
        exp_poll(post, pv, to);
        if (!to) begin push(1, 12'h800, pv); push(0, 12'h288, exp_rd); end
      end else ref_mem[addr[5:0]] = wd;
    end
    @(negedge clk);
    chk(req_ready, "R7 ready when idle", {31'b0, req_ready}, 1);
    t_n = 0; busy_left = pre; post_busy = post; have_busy = 0;
    req_valid = 1; req_write = wr; req_dev = dev; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    waited = 0; ready_bad = 0;
    while (!rsp_done && waited < 3000) begin
      if (req_ready) ready_bad = 1;
      if (inject && waited >= 3 && waited <= 6) begin
        req_valid = 1; req_write = ~wr; req_addr = ~addr;
      end else req_valid = 0;
      @(negedge clk);
      waited++;
    end
    req_valid = 0;
    chk(waited < 3000, "R8 done arrives", waited, 0);
    chk(!ready_bad, "R7 ready low while busy", {31'b0, ready_bad}, 0);
    chk(rsp_err == to, "R6 error flag", {31'b0, rsp_err}, {31'b0, to});
    if (!wr && !to) chk(rsp_rdata == exp_rd, "R8 read data", rsp_rdata, exp_rd);
    chk(t_n == e_n, wr ? "R4 transfer count" : "R3 transfer count", t_n, e_n);
    for (int i = 0; i < e_n && i < t_n; i++) begin
      if (t_wr[i] !== e_wr[i] || t_a[i] !== e_a[i] || t_d[i] !== e_d[i]) begin
        chk(0, (i % 2 == 0) ? "R1 page write" : (wr ? "R4 sequence" : "R3 sequence"),
            {t_wr[i], 7'b0, 12'b0, t_a[i]}, {e_wr[i], 7'b0, 12'b0, e_a[i]});
        $display("  step %0d data actual=%h expected=%h", i, t_d[i], e_d[i]);
        break;
      end
    end
    if (t_n > 1) chk(t_a[0] == 12'h800 && t_d[0] == pv, "R1 first page value", t_d[0], pv);
    if (t_n > 1) chk(t_a[1] == 12'h280, "R2 control offset", {20'b0, t_a[1]}, 32'h280);
    @(negedge clk);
    chk(!rsp_done, "R8 done single cycle", {31'b0, rsp_done}, 0);
    n_after = t_n;
    repeat (8) @(negedge clk);
    chk(t_n == n_after && !bus_wr && !bus_rd, to ? "R6 quiet after abort" : "R7 quiet after done",
        t_n, n_after);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 64; i++) begin
      phy_mem[i] = init_val(i);
      ref_mem[i] = init_val(i);
    end
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_wr && !bus_rd && !rsp_done, "R10 in reset",
        {28'b0, req_ready, bus_wr, bus_rd, rsp_done}, 32'h8);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !bus_wr && !bus_rd && !rsp_done, "R10 after reset",
        {28'b0, req_ready, bus_wr, bus_rd, rsp_done}, 32'h8);
    // directed corners
    do_req(0, 5'd3, 16'h1234, 0, 0, 0, 0);                // plain read
    do_req(1, 5'd3, 16'h1234, 32'hCAFE_0001, 2, 0, 0);    // write, busy first
    do_req(0, 5'd3, 16'h1234, 0, 1, 3, 0);                // read back written value
    do_req(1, 5'd31, 16'hFFFF, 32'h0BAD_F00D, PM-1, 0, 0);// longest legal wait
    do_req(0, 5'd31, 16'hFFFF, 0, 0, PM-1, 0);
    do_req(0, 5'd7, 16'h0042, 0, PM, 0, 0);               // R6 timeout before command
    do_req(0, 5'd9, 16'h0011, 0, 0, PM, 0);               // R6 timeout after command
    do_req(1, 5'd0, 16'h0000, 32'h1111_2222, 0, 0, 1);    // R7 valid while busy ignored
    do_req(0, 5'd0, 16'h0000, 0, 0, 0, 1);
    // random mix
    for (int k = 0; k < 40; k++) begin
      do_req($urandom % 2, 5'($urandom), 16'($urandom), $urandom,
             $urandom % 4, $urandom % 4, 0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule